// File: doc/BRIEF.md
# Multi-Channel PWM DAC Bank

This block drives fourteen pulse-width-modulated outputs, each acting as a coarse digital-to-analog converter once filtered off chip. Every channel owns an 8-bit duty register on a byte-addressed register interface. All channels compare their duty code against one shared period counter, which advances on a prescaled tick. The duty code sets how many ticks per period the output is high.

Two mode inputs shape the waveform. `fast_sel` picks between two tick rates, one exactly twice the other. `short_period` picks a period of 253 or 256 ticks. In the 253-tick mode the three highest codes saturate to a constant high. In the 256-tick mode even the top code leaves one low tick per period. Each channel keeps a shadow copy of its duty code, and that copy is only reloaded at a period boundary, so a register write never cuts a pulse short.

Top module: `pwm_dac_bank`

## Requirements
- R1: Channel k (0..13) has a readable and writable 8-bit duty register at byte address 20h+k. A write with `wr_en` high stores `wr_data`. `rd_data` shows the addressed register combinationally.
- R2: While `rst` is high every output is low. After reset every duty register reads 80h, and each output is high for half of each period.
- R3: With `fast_sel`=1 the counter advances once every PRESCALE_DIV clock cycles. With `fast_sel`=0 it advances once every 2*PRESCALE_DIV cycles.
- R4: With `short_period`=1 a period is 253 ticks long; with `short_period`=0 it is 256 ticks long.
- R5: With `short_period`=1, duty codes FDh, FEh and FFh hold the output high for the whole period.
- R6: With `short_period`=0, code FFh gives exactly one low tick per period.
- R7: Duty code 00h holds the output low in both period modes.
- R8: Below the saturation codes, an output is high for exactly D ticks per period, where D is its duty code.
- R9: A written duty code takes effect only from the next period boundary. The rest of the current period keeps the old pulse width.
- R10: Reads from any address outside 20h..2Dh return 00h. Writes to such addresses change no duty register and no output.
- R11: A change of either mode input restarts the period counter at 0. A change of `fast_sel` also restarts the prescaler.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fast_sel | input | 1 | 1: tick every PRESCALE_DIV cycles; 0: every 2*PRESCALE_DIV cycles |
| short_period | input | 1 | 1: 253-tick period; 0: 256-tick period |
| addr | input | 8 | Register byte address |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr` (00h when unmapped) |
| pwm_out | output | 14 | Registered PWM outputs, bit k is channel k |

## Verification
A wrong period counter or prescaler changes the number of high cycles in every full period window. That error shows on every active channel within one period of a few hundred cycles. A stale or early shadow load shows as a pulse-width change inside the period in which the write happened, and it is visible before the next wrap. A corrupted duty register shows at once on `rd_data`, and on the output from the following period.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;

    localparam int CHANNELS    = 14;
    localparam int DUTY_W      = 8;
    localparam int ADDR_W      = 8;
    localparam int BASE_ADDR   = 'h20;
    localparam int RESET_DUTY  = 'h80;
    localparam int PRESCALE    = 64;
    localparam int FULL_STEPS  = 256;
    localparam int SHORT_STEPS = 253;

    typedef logic [DUTY_W-1:0] duty_t;

    typedef struct packed {
        logic fast;
        logic short_p;
    } mode_t;

    // last counter value of a period for the selected length
    function automatic duty_t last_step(input logic short_p);
        return short_p ? duty_t'(SHORT_STEPS - 1) : duty_t'(FULL_STEPS - 1);
    endfunction

endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
    import pwm_bank_pkg::*;
#(
    parameter int DIV = PRESCALE
) (
    input  logic clk,
    input  logic rst,
    input  logic fast,
    input  logic clear,
    output logic tick
);
    localparam int W = $clog2(2 * DIV) + 1;

    logic [W-1:0] cnt;
    logic [W-1:0] limit;

    assign limit = fast ? W'(DIV - 1) : W'(2 * DIV - 1);
    assign tick  = (cnt == limit) && !clear;

    always_ff @(posedge clk) begin
        if (rst || clear)       cnt <= '0;
        else if (cnt >= limit)  cnt <= '0;
        else                    cnt <= cnt + W'(1);
    end

    // R3
    prescale_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= W'(2 * DIV - 1));

    // R11
    prescale_clear_chk: assert property (@(posedge clk) disable iff (rst)
        clear |=> (cnt == '0));

endmodule

// File: rtl/pwm_period_counter.sv
module pwm_period_counter
    import pwm_bank_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  tick,
    input  logic  short_p,
    input  logic  restart,
    output duty_t cnt,
    output logic  wrap
);
    duty_t last;

    assign last = last_step(short_p);
    assign wrap = tick && (cnt == last);

    always_ff @(posedge clk) begin
        if (rst || restart) cnt <= '0;
        else if (tick)      cnt <= wrap ? duty_t'(0) : cnt + duty_t'(1);
    end

    // R4
    period_range_chk: assert property (@(posedge clk) disable iff (rst)
        short_p |-> (cnt <= duty_t'(SHORT_STEPS - 1)));

    // R11
    restart_zero_chk: assert property (@(posedge clk) disable iff (rst)
        restart |=> (cnt == '0));

endmodule

// File: rtl/pwm_channel.sv
module pwm_channel
    import pwm_bank_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  duty_t duty,
    input  logic  load,
    input  duty_t cnt,
    input  logic  short_p,
    output logic  pwm
);
    duty_t shadow;
    logic  high;

    always_ff @(posedge clk) begin
        if (rst)       shadow <= duty_t'(RESET_DUTY);
        else if (load) shadow <= duty;
    end

    always_comb begin
        if (short_p && shadow >= duty_t'(SHORT_STEPS)) high = 1'b1;
        else                                           high = (shadow > cnt);
    end

    always_ff @(posedge clk) begin
        if (rst) pwm <= 1'b0;
        else     pwm <= high;
    end

    // R9
    shadow_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(shadow));

    // R7
    zero_low_chk: assert property (@(posedge clk) disable iff (rst)
        (shadow == '0) |=> !pwm);

    // R5
    saturate_high_chk: assert property (@(posedge clk) disable iff (rst)
        (short_p && shadow >= duty_t'(SHORT_STEPS)) |=> pwm);

    // R6
    top_code_low_chk: assert property (@(posedge clk) disable iff (rst)
        (!short_p && cnt == duty_t'(FULL_STEPS - 1)) |=> !pwm);

endmodule

// File: rtl/pwm_regs.sv
module pwm_regs
    import pwm_bank_pkg::*;
#(
    parameter int CH = CHANNELS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  duty_t             wr_data,
    output duty_t             rd_data,
    output duty_t             duty [CH]
);
    for (genvar k = 0; k < CH; k++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)                                           duty[k] <= duty_t'(RESET_DUTY);
            else if (wr_en && addr == ADDR_W'(BASE_ADDR + k))  duty[k] <= wr_data;
        end

        // R10
        reg_untouched_chk: assert property (@(posedge clk) disable iff (rst)
            !(wr_en && addr == ADDR_W'(BASE_ADDR + k)) |=> $stable(duty[k]));
    end

    always_comb begin
        rd_data = '0;
        for (int k = 0; k < CH; k++) begin
            if (addr == ADDR_W'(BASE_ADDR + k)) rd_data = duty[k];
        end
    end

endmodule

// File: rtl/pwm_dac_bank.sv
module pwm_dac_bank
    import pwm_bank_pkg::*;
#(
    parameter int CH           = CHANNELS,
    parameter int PRESCALE_DIV = PRESCALE
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fast_sel,
    input  logic              short_period,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DUTY_W-1:0] wr_data,
    output logic [DUTY_W-1:0] rd_data,
    output logic [CH-1:0]     pwm_out
);
    mode_t mode_q;
    mode_t mode_in;
    logic  freq_chg;
    logic  restart;
    logic  tick;
    logic  wrap;
    logic  load;
    duty_t cnt;
    duty_t duty [CH];

    assign mode_in  = '{fast: fast_sel, short_p: short_period};
    assign freq_chg = (mode_in.fast != mode_q.fast);
    assign restart  = (mode_in != mode_q);
    assign load     = wrap || restart;

    always_ff @(posedge clk) begin
        if (rst) mode_q <= '0;
        else     mode_q <= mode_in;
    end

    pwm_regs #(.CH(CH)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .addr    (addr),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .duty    (duty)
    );

    pwm_prescaler #(.DIV(PRESCALE_DIV)) u_prescale (
        .clk   (clk),
        .rst   (rst),
        .fast  (mode_q.fast),
        .clear (freq_chg),
        .tick  (tick)
    );

    pwm_period_counter u_period (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .short_p (mode_q.short_p),
        .restart (restart),
        .cnt     (cnt),
        .wrap    (wrap)
    );

    for (genvar k = 0; k < CH; k++) begin : g_ch
        pwm_channel u_ch (
            .clk     (clk),
            .rst     (rst),
            .duty    (duty[k]),
            .load    (load),
            .cnt     (cnt),
            .short_p (mode_q.short_p),
            .pwm     (pwm_out[k])
        );
    end

    // R2
    reset_low_chk: assert property (@(posedge clk)
        rst |=> (pwm_out == '0));

endmodule

// File: tb/pwm_dac_bank_bench.sv
module pwm_dac_bank_bench;

    localparam int CH  = 14;
    localparam int DIV = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        fast_sel = 1'b1;
    logic        short_period = 1'b0;
    logic [7:0]  addr = 8'h00;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = 8'h00;
    logic [7:0]  rd_data;
    logic [CH-1:0] pwm_out;

    int checks = 0;
    int errors = 0;

    typedef struct {
        int    ch;
        int    exp_high;
        int    window;
        string req;
    } item_t;

    item_t sb_q[$];

    always #2 clk = ~clk;

    pwm_dac_bank #(.CH(CH), .PRESCALE_DIV(DIV)) u_pwm_dac_bank (
        .clk          (clk),
        .rst          (rst),
        .fast_sel     (fast_sel),
        .short_period (short_period),
        .addr         (addr),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .rd_data      (rd_data),
        .pwm_out      (pwm_out)
    );

    // monitor: count high cycles of a channel over a window, compare
    initial begin
        forever begin
            item_t it;
            int    highs;
            wait (sb_q.size() > 0);
            it    = sb_q[0];
            highs = 0;
            for (int i = 0; i < it.window; i++) begin
                @(negedge clk);
                if (pwm_out[it.ch]) highs++;
            end
            checks++;
            if (highs != it.exp_high) begin
                errors++;
                $display("FAIL %s ch%0d high cycles actual %0d expected %0d",
                         it.req, it.ch, highs, it.exp_high);
            end
            void'(sb_q.pop_front());
        end
    end

    task automatic expect_high(input int ch, input int exp_high, input int window,
                               input string req);
        item_t it;
        it.ch = ch; it.exp_high = exp_high; it.window = window; it.req = req;
        sb_q.push_back(it);
        wait (sb_q.size() == 0);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic chk_read(input logic [7:0] a, input logic [7:0] exp, input string req);
        @(negedge clk);
        addr = a;
        #1;
        checks++;
        if (rd_data !== exp) begin
            errors++;
            $display("FAIL %s read %h actual %h expected %h", req, a, rd_data, exp);
        end
    endtask

    task automatic settle(input int cycles);
        repeat (cycles) @(negedge clk);
    endtask

    localparam int P_FAST  = 256 * DIV;
    localparam int P_SLOW  = 256 * 2 * DIV;
    localparam int P_SHORT = 253 * DIV;

    initial begin
        repeat (4) @(negedge clk);
        checks++;
        if (pwm_out !== '0) begin
            errors++;
            $display("FAIL R2 outputs in reset actual %h expected 0", pwm_out);
        end
        rst = 1'b0;

        for (int k = 0; k < CH; k++) chk_read(8'(8'h20 + k), 8'h80, "R2");
        settle(2 * P_FAST + 8);
        expect_high(3, 128 * DIV, P_FAST, "R2");

        // R1 / R8 / R7 / R6
        wr(8'h20, 8'h01);
        wr(8'h21, 8'h40);
        wr(8'h22, 8'hC8);
        wr(8'h25, 8'h00);
        wr(8'h2D, 8'hFF);
        chk_read(8'h20, 8'h01, "R1");
        chk_read(8'h22, 8'hC8, "R1");
        chk_read(8'h2D, 8'hFF, "R1");
        settle(2 * P_FAST + 8);
        expect_high(1, 64 * DIV, P_FAST, "R8");
        expect_high(2, 200 * DIV, P_FAST, "R8");
        expect_high(5, 0, P_FAST, "R7");
        expect_high(13, 255 * DIV, P_FAST, "R6");

        // R10: unmapped addresses
        wr(8'h2E, 8'h55);
        wr(8'h1F, 8'hAA);
        chk_read(8'h2E, 8'h00, "R10");
        chk_read(8'h1F, 8'h00, "R10");
        chk_read(8'h00, 8'h00, "R10");
        chk_read(8'h2D, 8'hFF, "R10");
        chk_read(8'h20, 8'h01, "R10");
        expect_high(0, 1 * DIV, P_FAST, "R10");

        // R3: slow tick rate
        fast_sel = 1'b0;
        settle(2 * P_SLOW + 8);
        expect_high(1, 64 * 2 * DIV, P_SLOW, "R3");
        expect_high(2, 200 * 2 * DIV, P_SLOW, "R3");

        // R4 / R5: 253-tick period
        fast_sel = 1'b1;
        short_period = 1'b1;
        wr(8'h24, 8'hFD);
        wr(8'h26, 8'hFE);
        wr(8'h27, 8'hFC);
        settle(2 * P_SHORT + 8);
        expect_high(4, P_SHORT, P_SHORT, "R5");
        expect_high(6, P_SHORT, P_SHORT, "R5");
        expect_high(13, P_SHORT, P_SHORT, "R5");
        expect_high(7, 252 * DIV, P_SHORT, "R4");
        expect_high(1, 64 * DIV, P_SHORT, "R4");
        expect_high(5, 0, P_SHORT, "R7");

        // R11: back to 256-tick period
        short_period = 1'b0;
        settle(2 * P_FAST + 8);
        expect_high(4, 253 * DIV, P_FAST, "R11");

        // R9: write mid-period is deferred to the next period
        @(posedge pwm_out[0]);
        @(negedge clk);
        settle(300);
        wr(8'h28, 8'hFF);
        expect_high(8, 0, 150, "R9");
        settle(2 * P_FAST + 8);
        expect_high(8, 255 * DIV, P_FAST, "R9");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule